// File: doc/BRIEF.md
# In-place Radix-2 FFT Address Generator

This block sequences one radix-2 decimation-in-time FFT processor that computes in place over two dual-port banks: a private bank (bank 0) and an auxiliary bank (bank 1). After a start pulse it steps through every butterfly pair of every pass. On each step it gives the read address for each bank, a swap control for the two butterfly inputs, a swap control for the two butterfly outputs, and a folded twiddle-ROM address. Placement follows the usual in-place rule. Element n starts in bank 0 when its index is even and in bank 1 when it is odd. When the last pass ends, results 0..63 sit at bank-0 addresses 0..63 in ascending order, and results 64..127 sit at bank-1 addresses 63..0 in descending order.

The generator is sized for a 128-point transform and can also run 32-point and 64-point transforms. The size is chosen at start. Internally a finite-state machine has three states. IDLE waits for a start pulse (transition IDLE→RUN on start). RUN emits one butterfly pair per cycle (transition RUN→FIN after the final pair of the final pass; otherwise it stays in RUN). FIN raises the done pulse for one cycle (transition FIN→IDLE, unconditional). In RUN, a pair counter counts up inside each pass and a pass counter counts down the passes that remain.

Top module: `fft_inplace_agen`

## Requirements
- R1: After reset, and at any time the block is not in RUN, `valid`, `done`, `pass_idx`, both bank addresses, both swap controls and `tw_addr` are all zero.
- R2: A `start` pulse in IDLE takes `size_sel` as the size: 0 gives 32 points (5 passes), 1 gives 64 points (6 passes), 2 gives 128 points (7 passes). In the cycle after the pulse, `valid`=1, `pass_idx`=1 and the pair index is 0.
- R3: An N-point run gives log2(N) passes of N/2 consecutive `valid` cycles each, with no gaps. `pass_idx` takes the values 1, 2, … in turn. Inside a pass, the pair index k counts 0..N/2-1.
- R4: In pass j, `b0_addr` equals k[5:0] with bit j-1 forced to 0. For j=7 no bit is cleared.
- R5: `b1_addr` equals `b0_addr` with its j-1 least significant bits inverted.
- R6: In pass j, `in_swap` equals bit j-1 of k and `out_swap` equals bit j of k.
- R7: Twiddle address: form a 10-bit word w whose top j+1 bits are k[j:0] and whose lower bits are 0. If w[9]=1, invert w[8:9-j]. `tw_addr` is w[8:0] after this fold.
- R8: `done` is high for exactly one cycle, in the cycle after the last `valid` cycle, and `valid` is low in that cycle.
- R9: A `start` pulse while a run is in progress has no effect. The run continues with its original size and sequence.
- R10: `size_sel`=3 runs a 128-point transform (7 passes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transform |
| size_sel | input | 2 | Transform size code, taken at start |
| valid | output | 1 | A butterfly pair is presented this cycle |
| pass_idx | output | 4 | Current pass number j, counting from 1 |
| b0_addr | output | 6 | Read address for bank 0 |
| b1_addr | output | 6 | Read address for bank 1 |
| in_swap | output | 1 | Swap the butterfly inputs and the read addresses |
| out_swap | output | 1 | Swap the butterfly outputs |
| tw_addr | output | 9 | Folded twiddle ROM address |
| done | output | 1 | One-cycle pulse when the transform ends |

## Verification
The bench builds the block with its default widths: a 10-bit pair counter, a 4-bit pass counter, 6-bit bank addresses and a 10-bit twiddle word. These widths make every pass of all three sizes reachable, including pass 7, where the clear bit lies outside the 6-bit address and the inversion mask covers the whole address. Every pair of every pass is compared against a model built from the bit rules. The stray-start case, the unused size code and a reset in the middle of a run are also covered.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;

    localparam int AGEN_PAIR_W = 10;
    localparam int AGEN_PASS_W = 4;
    localparam int AGEN_ADDR_W = 6;
    localparam int AGEN_TW_W   = 10;
    localparam int AGEN_LOG_MAX = AGEN_ADDR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } agen_state_t;

    function automatic logic [AGEN_PASS_W-1:0] passes_for(input logic [1:0] sel);
        logic [AGEN_PASS_W-1:0] n;
        unique case (sel)
            2'd0:    n = AGEN_PASS_W'(AGEN_LOG_MAX - 2);
            2'd1:    n = AGEN_PASS_W'(AGEN_LOG_MAX - 1);
            default: n = AGEN_PASS_W'(AGEN_LOG_MAX);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fft_pass_ctrl.sv
module fft_pass_ctrl
    import fft_agen_pkg::*;
#(
    parameter int PAIR_W = AGEN_PAIR_W,
    parameter int PASS_W = AGEN_PASS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size_sel,
    output logic              running,
    output logic              fin_pulse,
    output logic [PAIR_W-1:0] pair_cnt,
    output logic [PASS_W-1:0] pass_num
);

    agen_state_t       st_q, st_d;
    logic [PASS_W-1:0] rem_q, nlog_q;
    logic [PAIR_W-1:0] k_q, half_m1;
    logic              last_pair, last_pass;

    always_comb begin
        half_m1   = (PAIR_W'(1) << (nlog_q - PASS_W'(1))) - PAIR_W'(1);
        last_pair = (k_q == half_m1);
        last_pass = (rem_q == PASS_W'(1));
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_RUN;
            ST_RUN:  if (last_pair && last_pass) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // pair up-counter and pass down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q    <= '0;
            rem_q  <= PASS_W'(AGEN_LOG_MAX);
            nlog_q <= PASS_W'(AGEN_LOG_MAX);
        end else if (st_q == ST_IDLE && start) begin
            k_q    <= '0;
            rem_q  <= passes_for(size_sel);
            nlog_q <= passes_for(size_sel);
        end else if (st_q == ST_RUN) begin
            if (last_pair) begin
                k_q   <= '0;
                rem_q <= rem_q - PASS_W'(1);
            end else begin
                k_q <= k_q + PAIR_W'(1);
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        running   = 1'b0;
        fin_pulse = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RUN:  running = 1'b1;
            ST_FIN:  fin_pulse = 1'b1;
            default: ;
        endcase
        pair_cnt = k_q;
        pass_num = nlog_q - rem_q + PASS_W'(1);
    end

endmodule

// File: rtl/fft_bank_addr.sv
module fft_bank_addr
    import fft_agen_pkg::*;
#(
    parameter int PAIR_W = AGEN_PAIR_W,
    parameter int PASS_W = AGEN_PASS_W,
    parameter int ADDR_W = AGEN_ADDR_W
) (
    input  logic [PAIR_W-1:0] pair_cnt,
    input  logic [PASS_W-1:0] pass_num,
    output logic [ADDR_W-1:0] b0_addr,
    output logic [ADDR_W-1:0] b1_addr,
    output logic              in_swap,
    output logic              out_swap
);

    logic [ADDR_W-1:0] base, clr_bit, low_mask;
    logic [PAIR_W-1:0] sh_in, sh_out;

    always_comb begin
        base     = pair_cnt[ADDR_W-1:0];
        clr_bit  = ADDR_W'(1) << (pass_num - PASS_W'(1));
        low_mask = clr_bit - ADDR_W'(1);
        if (pass_num > PASS_W'(ADDR_W)) begin
            clr_bit  = '0;
            low_mask = '1;
        end
        b0_addr  = base & ~clr_bit;
        b1_addr  = b0_addr ^ low_mask;
        sh_in    = pair_cnt >> (pass_num - PASS_W'(1));
        sh_out   = pair_cnt >> pass_num;
        in_swap  = sh_in[0];
        out_swap = sh_out[0];
    end

endmodule

// File: rtl/fft_twiddle_fold.sv
module fft_twiddle_fold
    import fft_agen_pkg::*;
#(
    parameter int PAIR_W = AGEN_PAIR_W,
    parameter int PASS_W = AGEN_PASS_W,
    parameter int TW_W   = AGEN_TW_W
) (
    input  logic [PAIR_W-1:0] pair_cnt,
    input  logic [PASS_W-1:0] pass_num,
    output logic [TW_W-2:0]   tw_addr
);

    logic [PAIR_W-1:0] kmask;
    logic [TW_W-1:0]   kk, word, fmask, folded;
    logic [PASS_W-1:0] gap;

    always_comb begin
        kmask  = (PAIR_W'(1) << (pass_num + PASS_W'(1))) - PAIR_W'(1);
        kk     = TW_W'(pair_cnt & kmask);
        gap    = PASS_W'(TW_W - 1) - pass_num;
        word   = kk << gap;
        fmask  = ((TW_W'(1) << pass_num) - TW_W'(1)) << gap;
        folded = word[TW_W-1] ? (word ^ fmask) : word;
        tw_addr = folded[TW_W-2:0];
    end

endmodule

// File: rtl/fft_inplace_agen.sv
module fft_inplace_agen
    import fft_agen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] size_sel,
    output logic       valid,
    output logic [3:0] pass_idx,
    output logic [5:0] b0_addr,
    output logic [5:0] b1_addr,
    output logic       in_swap,
    output logic       out_swap,
    output logic [8:0] tw_addr,
    output logic       done
);

    logic                   running, fin_pulse;
    logic [AGEN_PAIR_W-1:0] pair_cnt;
    logic [AGEN_PASS_W-1:0] pass_num;
    logic [AGEN_ADDR_W-1:0] b0_raw, b1_raw;
    logic                   isw_raw, osw_raw;
    logic [AGEN_TW_W-2:0]   tw_raw;

    fft_pass_ctrl #(.PAIR_W(AGEN_PAIR_W), .PASS_W(AGEN_PASS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .running(running), .fin_pulse(fin_pulse),
        .pair_cnt(pair_cnt), .pass_num(pass_num)
    );

    fft_bank_addr #(.PAIR_W(AGEN_PAIR_W), .PASS_W(AGEN_PASS_W), .ADDR_W(AGEN_ADDR_W)) u_bank (
        .pair_cnt(pair_cnt), .pass_num(pass_num),
        .b0_addr(b0_raw), .b1_addr(b1_raw),
        .in_swap(isw_raw), .out_swap(osw_raw)
    );

    fft_twiddle_fold #(.PAIR_W(AGEN_PAIR_W), .PASS_W(AGEN_PASS_W), .TW_W(AGEN_TW_W)) u_tw (
        .pair_cnt(pair_cnt), .pass_num(pass_num), .tw_addr(tw_raw)
    );

    always_comb begin
        valid    = running;
        done     = fin_pulse;
        pass_idx = running ? pass_num : '0;
        b0_addr  = running ? b0_raw : '0;
        b1_addr  = running ? b1_raw : '0;
        in_swap  = running & isw_raw;
        out_swap = running & osw_raw;
        tw_addr  = running ? tw_raw : '0;
    end

endmodule

// File: rtl/fft_agen_chk.sv
module fft_agen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid,
    input logic       done,
    input logic [3:0] pass_idx,
    input logic [5:0] b0_addr,
    input logic [5:0] b1_addr
);

    // R8: valid and done never coincide
    a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    // R8: done only directly after a valid cycle
    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid));

    // R3: pass number holds or advances by one between valid cycles
    a_r3_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |->
        (pass_idx == $past(pass_idx) || pass_idx == $past(pass_idx) + 4'd1));

    // R4: bit j-1 of the bank-0 address is clear for passes 1..6
    a_r4_b0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && pass_idx <= 4'd6) |-> (((b0_addr >> (pass_idx - 4'd1)) & 6'd1) == 6'd0));

    // R5: bank addresses agree above the inverted low bits
    a_r5_upper_match: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((b0_addr >> (pass_idx - 4'd1)) == (b1_addr >> (pass_idx - 4'd1))));

    // R1: outside a run the addresses rest at zero
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (b0_addr == 6'd0 && b1_addr == 6'd0 && pass_idx == 4'd0));

endmodule

bind fft_inplace_agen fft_agen_chk u_agen_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .done(done),
    .pass_idx(pass_idx), .b0_addr(b0_addr), .b1_addr(b1_addr)
);

// File: tb/fft_inplace_agen_tb.sv
module fft_inplace_agen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] size_sel = 2'd0;
    logic       valid, in_swap, out_swap, done;
    logic [3:0] pass_idx;
    logic [5:0] b0_addr, b1_addr;
    logic [8:0] tw_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fft_inplace_agen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .valid(valid), .pass_idx(pass_idx), .b0_addr(b0_addr), .b1_addr(b1_addr),
        .in_swap(in_swap), .out_swap(out_swap), .tw_addr(tw_addr), .done(done)
    );

    // case table: size code, expected passes, expected valid cycles, stray start
    localparam int NCASE = 5;
    localparam int CASE_SEL  [NCASE] = '{0, 1, 2, 3, 1};
    localparam int CASE_LOG  [NCASE] = '{5, 6, 7, 7, 6};
    localparam int CASE_CYC  [NCASE] = '{80, 192, 448, 448, 192};
    localparam int CASE_POKE [NCASE] = '{0, 0, 0, 0, 1};

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_tw(input int k, input int j);
        int w;
        w = (k & ((1 << (j + 1)) - 1)) << (9 - j);
        if (((w >> 9) & 1) == 1) w = w ^ (((1 << j) - 1) << (9 - j));
        return w & 511;
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " R1 valid"}, int'(valid), 0);
        chk({tag, " R1 done"}, int'(done), 0);
        chk({tag, " R1 b0"}, int'(b0_addr), 0);
        chk({tag, " R1 b1"}, int'(b1_addr), 0);
        chk({tag, " R1 tw"}, int'(tw_addr), 0);
        chk({tag, " R1 pass"}, int'(pass_idx), 0);
    endtask

    task automatic run_case(input int sel, input int lg, input int cyc, input int poke);
        int n;
        int b0e;
        n = 0;
        @(negedge clk);
        size_sel = 2'(sel);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= lg; j++) begin
            for (int k = 0; k < (1 << (lg - 1)); k++) begin
                b0e = (k & 63) & ~(1 << (j - 1)) & 63;
                chk("R2/R3 valid", int'(valid), 1);
                chk("R2/R3 pass_idx", int'(pass_idx), j);
                chk("R4 b0_addr", int'(b0_addr), b0e);
                chk("R5 b1_addr", int'(b1_addr), (b0e ^ ((1 << (j - 1)) - 1)) & 63);
                chk("R6 in_swap", int'(in_swap), (k >> (j - 1)) & 1);
                chk("R6 out_swap", int'(out_swap), (k >> j) & 1);
                chk("R7 tw_addr", int'(tw_addr), exp_tw(k, j));
                n++;
                if (poke != 0 && j == 2 && k == 3) begin
                    start = 1'b1;   // R9: stray start with another size
                    size_sel = 2'd2;
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk("R3 valid cycles", n, cyc);
        chk("R8 done high", int'(done), 1);
        chk("R8 valid low at done", int'(valid), 0);
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
        check_idle("post-run");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        for (int c = 0; c < NCASE; c++)   // R2 R3 R9 R10 via the table
            run_case(CASE_SEL[c], CASE_LOG[c], CASE_CYC[c], CASE_POKE[c]);

        // R1: reset in the middle of a run returns to rest
        @(negedge clk);
        size_sel = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 mid-run active", int'(valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("released");

        run_case(0, 5, 80, 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule